// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is a watchdog peripheral on a 16-bit register port with single-cycle access. A 32-bit down-counter runs from a programmable prescaler. When the counter runs out, the block raises a one-cycle reset request, adds one to a saturating event counter and reloads itself from the programmed timeout. Firmware keeps the system alive by writing two fixed 16-bit keys to the service register within a short cycle window.

The configuration registers are locked. A configuration window is open for a bounded number of cycles after reset. After that, the window reopens only when two unlock keys are written back to back, and only if the allow-update bit permits it. An optional window mode treats a service that arrives too early, while the counter is still above a programmed window value, as a fault.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, the control register (offset 0x00) reads 0x01D3. Bit 0 is enable, bit 3 is window mode and bit 4 is allow-update. The timeout low half (0x06) and the prescaler (0x16) read 0x0400, the reset-event count (0x14) reads 0 and `rstReq` is low.
- R2: A service takes effect when 0xA602 is written to offset 0x0C and 0xB480 follows to 0x0C no more than 20 cycles later. The service reloads the counter from the timeout value {0x04, 0x06}.
- R3: A service sequence is dropped if a write to 0x0C other than the awaited key arrives, or if the second key comes more than 20 cycles after the first. The counter is then not reloaded.
- R4: Writing 0xC520 and then 0xD928 to offset 0x0E, at most 20 cycles apart, reopens the configuration window.
- R5: Writes to the configuration registers (0x00, 0x04, 0x06, 0x08, 0x0A, 0x16) take effect only in the 256 cycles that follow the unlock cycle, or in the first 256 cycles after reset. Outside that window they are ignored.
- R6: With allow-update at 0, an unlock sequence after the window has closed leaves the registers locked.
- R7: While enabled, the counter steps down once every (prescaler[10:8]+1) cycles. A step taken at zero raises `rstReq` for one cycle and reloads the timeout.
- R8: With enable at 0, the counter holds and `rstReq` stays low.
- R9: With window mode on, a service that completes while the counter is above the window value {0x08, 0x0A} raises `rstReq`. A service at or below that value does not.
- R10: Every reset request adds one to the reset-event count, which stops at 0xFFFF. Writing 1s to offset 0x14 clears those bits at any time.
- R11: Reading the timer high half (0x10) returns counter bits 31:16 and latches bits 15:0. A later read of 0x12 returns the latched value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe |
| busAddr | input | 5 | Byte offset of the 16-bit register |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, combinational from `busAddr` |
| rstReq | output | 1 | Reset request pulse |

## Verification
Assertions check the following on every cycle:
- A service or unlock strobe appears only together with the matching second key on the right offset.
- A closed configuration window stays closed unless an allowed unlock arrives.
- A control write outside the window leaves the control register unchanged.
- A disabled watchdog never requests a reset.

Some behaviour needs the bench's scenarios and its cycle-accurate model:
- the exact 20-cycle and 256-cycle boundaries
- prescaled counting
- early-service faults
- saturation and write-one-clear of the event count
- the latched timer readback

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;
  localparam int REG_W = 16;

  localparam int OFS_CTRLH   = 'h00;
  localparam int OFS_CTRLL   = 'h02;
  localparam int OFS_TOUTH   = 'h04;
  localparam int OFS_TOUTL   = 'h06;
  localparam int OFS_WINH    = 'h08;
  localparam int OFS_WINL    = 'h0A;
  localparam int OFS_SERVICE = 'h0C;
  localparam int OFS_UNLOCK  = 'h0E;
  localparam int OFS_TMRH    = 'h10;
  localparam int OFS_TMRL    = 'h12;
  localparam int OFS_RCNT    = 'h14;
  localparam int OFS_PRESC   = 'h16;

  localparam logic [REG_W-1:0] SERVICE_KEY_A = 16'hA602;
  localparam logic [REG_W-1:0] SERVICE_KEY_B = 16'hB480;
  localparam logic [REG_W-1:0] UNLOCK_KEY_A  = 16'hC520;
  localparam logic [REG_W-1:0] UNLOCK_KEY_B  = 16'hD928;
  localparam logic [REG_W-1:0] CTRL_RST      = 16'h01D3;

  localparam int EN_BIT  = 0;
  localparam int WIN_BIT = 3;
  localparam int UPD_BIT = 4;

  typedef struct packed {
    logic serviceOk;
    logic unlockOk;
    logic cfgOpen;
  } wdtStrobes_t;
endpackage

// File: rtl/keyed_wdt_seqdet.sv
module keyed_wdt_seqdet #(
  parameter int KEY_GAP = 20,
  parameter logic [15:0] KEY_A = 16'h0000,
  parameter logic [15:0] KEY_B = 16'h0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrHit,
  input  logic [15:0] wrData,
  output logic        seqOk
);
  localparam int GAP_W = $clog2(KEY_GAP + 2);

  logic             armed;
  logic [GAP_W-1:0] gap;

  assign seqOk = wrHit && armed && (wrData == KEY_B) && (gap <= GAP_W'(KEY_GAP));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
      gap   <= '0;
    end else if (wrHit) begin
      if (seqOk) begin
        armed <= 1'b0;
      end else if (wrData == KEY_A) begin
        armed <= 1'b1;
        gap   <= GAP_W'(1);
      end else begin
        armed <= 1'b0;
      end
    end else if (armed && (gap <= GAP_W'(KEY_GAP))) begin
      gap <= gap + GAP_W'(1);
    end
  end
endmodule

// File: rtl/keyed_wdt_ctrl.sv
module keyed_wdt_ctrl
  import keyed_wdt_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int KEY_GAP = 20,
  parameter int CFG_WIN = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWdata,
  input  logic              allowUpd,
  output wdtStrobes_t       strb
);
  localparam int WIN_W = $clog2(CFG_WIN + 1);

  logic             serviceHit, unlockHit, serviceOk, unlockOk;
  logic [WIN_W-1:0] winLeft;

  assign serviceHit = busWe && (busAddr == ADDR_W'(OFS_SERVICE));
  assign unlockHit  = busWe && (busAddr == ADDR_W'(OFS_UNLOCK));

  keyed_wdt_seqdet #(.KEY_GAP(KEY_GAP), .KEY_A(SERVICE_KEY_A), .KEY_B(SERVICE_KEY_B)) serviceDet_i (
    .clk(clk), .rstN(rstN), .wrHit(serviceHit), .wrData(busWdata), .seqOk(serviceOk)
  );

  keyed_wdt_seqdet #(.KEY_GAP(KEY_GAP), .KEY_A(UNLOCK_KEY_A), .KEY_B(UNLOCK_KEY_B)) unlockDet_i (
    .clk(clk), .rstN(rstN), .wrHit(unlockHit), .wrData(busWdata), .seqOk(unlockOk)
  );

  always_comb begin
    strb.serviceOk = serviceOk;
    strb.unlockOk  = unlockOk;
    strb.cfgOpen   = (winLeft != '0);
  end

  // Window opens out of reset and reopens on an allowed unlock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winLeft <= WIN_W'(CFG_WIN);
    end else if (unlockOk && (allowUpd || strb.cfgOpen)) begin
      winLeft <= WIN_W'(CFG_WIN);
    end else if (strb.cfgOpen) begin
      winLeft <= winLeft - WIN_W'(1);
    end
  end
endmodule

// File: rtl/keyed_wdt_dp.sv
module keyed_wdt_dp
  import keyed_wdt_pkg::*;
#(
  parameter int          ADDR_W    = 5,
  parameter logic [31:0] TOUT_RST  = 32'h0000_0400,
  parameter logic [31:0] WIN_RST   = 32'h0000_0010,
  parameter logic [15:0] PRESC_RST = 16'h0400
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWdata,
  input  wdtStrobes_t       strb,
  output logic [REG_W-1:0]  busRdata,
  output logic [REG_W-1:0]  ctrlQ,
  output logic              rstReq
);
  localparam int CNT_W = 2 * REG_W;

  logic [REG_W-1:0] toutH, toutL, winH, winL, presc, rcnt, shadowL;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       presCnt;
  logic             en, tick, winErr, expire, reload, errEv, cfgWr;
  logic [REG_W-1:0] rcBase, rcNext;

  always_comb begin
    en     = ctrlQ[EN_BIT];
    tick   = en && (presCnt == presc[10:8]);
    winErr = strb.serviceOk && en && ctrlQ[WIN_BIT] && (cnt > {winH, winL});
    expire = tick && (cnt == '0) && !strb.serviceOk;
    reload = strb.serviceOk || expire;
    errEv  = winErr || expire;
    cfgWr  = busWe && strb.cfgOpen;
    rcBase = (busWe && busAddr == ADDR_W'(OFS_RCNT)) ? (rcnt & ~busWdata) : rcnt;
    rcNext = (errEv && rcBase != '1) ? rcBase + REG_W'(1) : rcBase;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ   <= CTRL_RST;
      toutH   <= TOUT_RST[CNT_W-1:REG_W];
      toutL   <= TOUT_RST[REG_W-1:0];
      winH    <= WIN_RST[CNT_W-1:REG_W];
      winL    <= WIN_RST[REG_W-1:0];
      presc   <= PRESC_RST;
      rcnt    <= '0;
      shadowL <= '0;
      cnt     <= TOUT_RST;
      presCnt <= '0;
      rstReq  <= 1'b0;
    end else begin
      rstReq <= errEv;
      rcnt   <= rcNext;
      if (reload) begin
        cnt     <= {toutH, toutL};
        presCnt <= '0;
      end else if (tick) begin
        cnt     <= cnt - CNT_W'(1);
        presCnt <= '0;
      end else if (en) begin
        presCnt <= presCnt + 3'd1;
      end
      if (busRe && busAddr == ADDR_W'(OFS_TMRH)) shadowL <= cnt[REG_W-1:0];
      if (cfgWr) begin
        case (busAddr)
          ADDR_W'(OFS_CTRLH): ctrlQ <= busWdata;
          ADDR_W'(OFS_TOUTH): toutH <= busWdata;
          ADDR_W'(OFS_TOUTL): toutL <= busWdata;
          ADDR_W'(OFS_WINH):  winH  <= busWdata;
          ADDR_W'(OFS_WINL):  winL  <= busWdata;
          ADDR_W'(OFS_PRESC): presc <= busWdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (busAddr)
      ADDR_W'(OFS_CTRLH): busRdata = ctrlQ;
      ADDR_W'(OFS_TOUTH): busRdata = toutH;
      ADDR_W'(OFS_TOUTL): busRdata = toutL;
      ADDR_W'(OFS_WINH):  busRdata = winH;
      ADDR_W'(OFS_WINL):  busRdata = winL;
      ADDR_W'(OFS_TMRH):  busRdata = cnt[CNT_W-1:REG_W];
      ADDR_W'(OFS_TMRL):  busRdata = shadowL;
      ADDR_W'(OFS_RCNT):  busRdata = rcnt;
      ADDR_W'(OFS_PRESC): busRdata = presc;
      default:            busRdata = '0;
    endcase
  end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import keyed_wdt_pkg::*;
#(
  parameter int          ADDR_W    = 5,
  parameter int          KEY_GAP   = 20,
  parameter int          CFG_WIN   = 256,
  parameter logic [31:0] TOUT_RST  = 32'h0000_0400,
  parameter logic [31:0] WIN_RST   = 32'h0000_0010,
  parameter logic [15:0] PRESC_RST = 16'h0400
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [15:0]       busWdata,
  output logic [15:0]       busRdata,
  output logic              rstReq
);
  wdtStrobes_t      strb;
  logic [REG_W-1:0] ctrlQ;

  keyed_wdt_ctrl #(.ADDR_W(ADDR_W), .KEY_GAP(KEY_GAP), .CFG_WIN(CFG_WIN)) ctrl_i (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .allowUpd(ctrlQ[UPD_BIT]), .strb(strb)
  );

  keyed_wdt_dp #(.ADDR_W(ADDR_W), .TOUT_RST(TOUT_RST), .WIN_RST(WIN_RST), .PRESC_RST(PRESC_RST)) dp_i (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr), .busWdata(busWdata),
    .strb(strb), .busRdata(busRdata), .ctrlQ(ctrlQ), .rstReq(rstReq)
  );
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk
  import keyed_wdt_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [REG_W-1:0]  busWdata,
  input wdtStrobes_t       strb,
  input logic [REG_W-1:0]  ctrlQ,
  input logic              rstReq
);
  // R2
  service_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.serviceOk |-> (busWe && busAddr == ADDR_W'(OFS_SERVICE) && busWdata == SERVICE_KEY_B));

  // R4
  unlock_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.unlockOk |-> (busWe && busAddr == ADDR_W'(OFS_UNLOCK) && busWdata == UNLOCK_KEY_B));

  // R6
  stays_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.cfgOpen && !(strb.unlockOk && ctrlQ[UPD_BIT])) |=> !strb.cfgOpen);

  // R5
  ctrl_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'(OFS_CTRLH) && !strb.cfgOpen) |=> $stable(ctrlQ));

  // R8
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlQ[EN_BIT] |=> !rstReq);
endmodule

bind keyed_wdt keyed_wdt_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
  .strb(strb), .ctrlQ(ctrlQ), .rstReq(rstReq)
);

// File: tb/keyed_wdt_tb_top.sv
module keyed_wdt_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0, busRe = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        rstReq;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  keyed_wdt dut_i (.clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
                   .busWdata(busWdata), .busRdata(busRdata), .rstReq(rstReq));

  // Behavioural reference state
  logic [15:0] mCtrl = 16'h01D3, mTovH = 16'h0, mTovL = 16'h0400, mWinH = 16'h0, mWinL = 16'h0010;
  logic [15:0] mPresc = 16'h0400, mRcnt = 16'h0, mShadow = 16'h0;
  logic [31:0] mCnt = 32'h400;
  int  mPc = 0, cyc = 0, cfgUntil = 256, refT = 0, unT = 0;
  bit  refArm = 0, unArm = 0, mRstReq = 0;

  function automatic logic [15:0] mRead(input logic [4:0] a);
    case (a)
      5'h00: return mCtrl;
      5'h04: return mTovH;
      5'h06: return mTovL;
      5'h08: return mWinH;
      5'h0A: return mWinL;
      5'h10: return mCnt[31:16];
      5'h12: return mShadow;
      5'h14: return mRcnt;
      5'h16: return mPresc;
      default: return 16'h0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic cycle(input logic we, input logic re, input logic [4:0] addr,
                       input logic [15:0] data, input string req);
    int edgeN;
    bit refOk, unOk, open, en, tick, winErr, expire, err, oldAllow;
    logic [15:0] base;
    busWe = we; busRe = re; busAddr = addr; busWdata = data;
    #1;
    if (re) chk(req, busRdata, mRead(addr));
    edgeN = cyc + 1;
    en = mCtrl[0];
    open = (edgeN <= cfgUntil);
    oldAllow = mCtrl[4];
    refOk = we && addr == 5'h0C && refArm && data == 16'hB480 && (edgeN - refT) <= 20;
    if (we && addr == 5'h0C) begin
      if (refOk) refArm = 0;
      else if (data == 16'hA602) begin refArm = 1; refT = edgeN; end
      else refArm = 0;
    end
    unOk = we && addr == 5'h0E && unArm && data == 16'hD928 && (edgeN - unT) <= 20;
    if (we && addr == 5'h0E) begin
      if (unOk) unArm = 0;
      else if (data == 16'hC520) begin unArm = 1; unT = edgeN; end
      else unArm = 0;
    end
    tick   = en && (mPc == int'(mPresc[10:8]));
    winErr = refOk && en && mCtrl[3] && (mCnt > {mWinH, mWinL});
    expire = tick && mCnt == 0 && !refOk;
    err    = winErr || expire;
    base = (we && addr == 5'h14) ? (mRcnt & ~data) : mRcnt;
    if (err && base != 16'hFFFF) base = base + 16'd1;
    mRcnt = base;
    if (re && addr == 5'h10) mShadow = mCnt[15:0];
    if (refOk || expire) begin mCnt = {mTovH, mTovL}; mPc = 0; end
    else if (tick) begin mCnt = mCnt - 1; mPc = 0; end
    else if (en) mPc = mPc + 1;
    if (we && open) begin
      case (addr)
        5'h00: mCtrl = data;
        5'h04: mTovH = data;
        5'h06: mTovL = data;
        5'h08: mWinH = data;
        5'h0A: mWinL = data;
        5'h16: mPresc = data;
        default: ;
      endcase
    end
    if (unOk && (oldAllow || open)) cfgUntil = edgeN + 256;
    mRstReq = err;
    cyc = edgeN;
    @(posedge clk); #1;
    // R7: reset request compared with the model every cycle
    chk("R7", {15'b0, rstReq}, {15'b0, mRstReq});
    busWe = 0; busRe = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d); cycle(1, 0, a, d, ""); endtask
  task automatic rd(input logic [4:0] a, input string req); cycle(0, 1, a, 16'h0, req); endtask
  task automatic idle(input int n); for (int i = 0; i < n; i++) cycle(0, 0, 5'h0, 16'h0, ""); endtask
  task automatic service(); wr(5'h0C, 16'hA602); wr(5'h0C, 16'hB480); endtask
  task automatic unlock(); wr(5'h0E, 16'hC520); wr(5'h0E, 16'hD928); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    chk("R1", {15'b0, rstReq}, 16'h0);
    rd(5'h00, "R1"); chk("R1", busRdata, 16'h01D3);
    rd(5'h14, "R1"); rd(5'h06, "R1"); rd(5'h16, "R1");

    // Program inside the post-reset window, then service
    wr(5'h04, 16'h0000); wr(5'h06, 16'd40); wr(5'h16, 16'h0100);
    service(); rd(5'h10, "R2"); rd(5'h12, "R2");
    chk("R2", busRdata, 16'd40);
    idle(6);
    wr(5'h0C, 16'hA602); idle(19); wr(5'h0C, 16'hB480);   // second key exactly 20 cycles later
    rd(5'h10, "R2"); rd(5'h12, "R2");

    // R3: wrong key and late key are both rejected
    wr(5'h0C, 16'hA602); wr(5'h0C, 16'h1234); wr(5'h0C, 16'hB480);
    rd(5'h10, "R3"); rd(5'h12, "R3");
    wr(5'h0C, 16'hA602); idle(20); wr(5'h0C, 16'hB480);
    rd(5'h10, "R3"); rd(5'h12, "R3");

    // R7: let it expire
    for (int i = 0; i < 200 && !mRstReq; i++) idle(1);
    chk("R7", {15'b0, rstReq}, 16'h1);
    rd(5'h14, "R10");

    // R5: after the post-reset window the registers are locked
    while (cyc <= 257) idle(1);
    wr(5'h06, 16'd99); rd(5'h06, "R5"); chk("R5", busRdata, 16'd40);

    // R4/R5: unlock reopens, exact window boundary
    unlock(); wr(5'h06, 16'd30); rd(5'h06, "R4"); chk("R4", busRdata, 16'd30);
    while (cyc + 1 < cfgUntil) idle(1);
    wr(5'h06, 16'd25); wr(5'h06, 16'd26);
    rd(5'h06, "R5"); chk("R5", busRdata, 16'd25);

    // R9: window mode
    unlock(); wr(5'h08, 16'h0); wr(5'h0A, 16'd10); wr(5'h00, 16'h01DB);
    service(); service();
    chk("R9", {15'b0, rstReq}, 16'h1);
    for (int i = 0; i < 200 && !(mCnt <= 10 && mCnt > 2); i++) idle(1);
    service();
    chk("R9", {15'b0, rstReq}, 16'h0);
    wr(5'h00, 16'h01D3); rd(5'h00, "R9");

    // R10: saturation and write-one-clear
    unlock(); wr(5'h06, 16'h0); wr(5'h16, 16'h0000); service();
    idle(65600);
    rd(5'h14, "R10"); chk("R10", busRdata, 16'hFFFF);
    wr(5'h14, 16'h00F0); rd(5'h14, "R10");
    unlock(); wr(5'h06, 16'd40); wr(5'h16, 16'h0100); service();
    wr(5'h14, 16'hFFFF); rd(5'h14, "R10"); chk("R10", busRdata, 16'h0);

    // R11: latched low half
    idle(3); rd(5'h10, "R11"); idle(6); rd(5'h12, "R11");

    // R8 and R6: disable with allow-update cleared, then try to reopen
    wr(5'h00, 16'h01C2);
    idle(300);
    rd(5'h10, "R8"); rd(5'h12, "R8"); idle(10); rd(5'h10, "R8"); rd(5'h12, "R8");
    unlock(); wr(5'h00, 16'h01D3); wr(5'h06, 16'd77);
    rd(5'h00, "R6"); chk("R6", busRdata, 16'h01C2);
    rd(5'h06, "R6"); chk("R6", busRdata, 16'd40);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule